// File: doc/BRIEF.md
# Gated Inter-Pulse Interval Timer

This block measures how long an asynchronous trigger input stays active. Time is counted in clock ticks. With the intended 20 MHz clock, one tick is 50 ns and the default 32-bit counter covers roughly 214 seconds. The trigger first passes through a multi-stage synchroniser. While the synchronised trigger is low, the tick counter is held at zero. While it is high, the counter advances by one every clock.

When the synchronised trigger falls, the block latches the count as one measurement and raises a valid strobe for a single cycle. Two rules shape the latched result. A result is never zero: any active interval the synchroniser saw is reported as at least one tick. If the counter wrapped during the interval, a sticky overflow flag is reported with the result, and that flag is cleared when the next active interval begins.

The block also drives a busy output that follows the synchronised trigger. A ready output rises once the block has left reset and stays high.

Top module: `ipt_gated_timer`

## Requirements
- R1: The trigger passes through SYNC_STAGES flip-flops (default 2). `busy_o` first shows a new trigger level SYNC_STAGES rising clock edges after the input changes.
- R2: `meas_ticks_o` equals the number of clock cycles for which the synchronised trigger was high during the interval just ended, taken modulo 2^CNT_W.
- R3: The counter is held at zero while the synchronised trigger is low. An idle gap of any length therefore adds nothing to the next measurement.
- R4: `meas_valid_o` is high for exactly one cycle per interval. That cycle is the one immediately after `busy_o` first reads low.
- R5: `meas_ticks_o` is never zero while `meas_valid_o` is high. A count of zero (an exact wrap) is reported as 1, and a single-cycle interval reports 1.
- R6: `meas_ovf_o` is 1 with the result when the count passed 2^CNT_W - 1 during the interval, and 0 otherwise.
- R7: The overflow flag is cleared at the start of each new active interval, so an overflow does not carry into later results.
- R8: While `rst_i` is high: `meas_valid_o`, `meas_ovf_o`, `busy_o` and `ready_o` are 0 and `meas_ticks_o` is all zeros.
- R9: `ready_o` is 1 from the first rising edge at which `rst_i` is low, and it stays 1 until reset.
- R10: `busy_o` is 1 for exactly as many cycles as the interval counted, that is, for the whole synchronised active time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock (20 MHz intended) |
| rst_i | input | 1 | Synchronous active-high reset |
| trig_i | input | 1 | Asynchronous gate; high means measuring |
| busy_o | output | 1 | Synchronised trigger level |
| ready_o | output | 1 | Block configured and running |
| meas_valid_o | output | 1 | One-cycle strobe marking a new result |
| meas_ticks_o | output | CNT_W | Measured interval in ticks, minimum 1 |
| meas_ovf_o | output | 1 | Counter wrapped during the measured interval |

## Verification
The bench builds the block with CNT_W set to 8, so the counter wraps after 256 ticks. This puts the overflow cases within a few hundred cycles of simulation: an exact wrap that must clamp to 1, a wrap that leaves a remainder, and clearing of the flag on the next interval. SYNC_STAGES stays at 2. Every result and busy edge is checked at the exact cycle implied by the two synchroniser stages plus the one capture register.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

    // Edge information derived from the synchronised trigger
    typedef struct packed {
        logic level;   // synchronised trigger level
        logic rise;    // inactive -> active this cycle
        logic fall;    // active -> inactive this cycle
    } gate_edge_t;

    // Flags travelling with a captured measurement
    typedef struct packed {
        logic valid;
        logic ovf;
    } meas_flags_t;

    // Flags cleared
    localparam meas_flags_t FLAGS_IDLE = '{valid: 1'b0, ovf: 1'b0};

endpackage

// File: rtl/ipt_sync.sv
module ipt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[0] <= 1'b0;
                    else       chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk_i) begin
                    if (rst_i) chain_q[i] <= 1'b0;
                    else       chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/ipt_edge.sv
module ipt_edge
    import ipt_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       level_i,
    output gate_edge_t edge_o
);
    logic prev_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) prev_q <= 1'b0;
        else       prev_q <= level_i;
    end

    always_comb begin
        edge_o.level = level_i;
        edge_o.rise  = level_i & ~prev_q;
        edge_o.fall  = ~level_i & prev_q;
    end
endmodule

// File: rtl/ipt_counter.sv
module ipt_counter
    import ipt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  gate_edge_t       edge_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrapped_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;
    logic             wrap_q;

    // Counter: cleared while the gate is low, advancing while it is high
    always_ff @(posedge clk_i) begin
        if (rst_i || !edge_i.level) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end

    // Sticky wrap flag: cleared when an interval starts, set when the count rolls over
    always_ff @(posedge clk_i) begin
        if (rst_i || edge_i.rise)                     wrap_q <= 1'b0;
        else if (edge_i.level && (cnt_q == CNT_MAX))  wrap_q <= 1'b1;
    end

    assign count_o   = cnt_q;
    assign wrapped_o = wrap_q;
endmodule

// File: rtl/ipt_gated_timer.sv
module ipt_gated_timer
    import ipt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             trig_i,
    output logic             busy_o,
    output logic             ready_o,
    output logic             meas_valid_o,
    output logic [CNT_W-1:0] meas_ticks_o,
    output logic             meas_ovf_o
);
    localparam logic [CNT_W-1:0] MIN_TICKS = {{(CNT_W-1){1'b0}}, 1'b1};

    logic             trig_s;
    gate_edge_t       gate;
    logic [CNT_W-1:0] count;
    logic             wrapped;
    logic [CNT_W-1:0] ticks_q;
    meas_flags_t      flags_q;
    logic             ready_q;

    ipt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (trig_i),
        .sync_o  (trig_s)
    );

    ipt_edge u_edge (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .level_i (trig_s),
        .edge_o  (gate)
    );

    ipt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .edge_i    (gate),
        .count_o   (count),
        .wrapped_o (wrapped)
    );

    // Capture on the falling gate edge; a zero count is raised to one tick
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ticks_q <= '0;
            flags_q <= FLAGS_IDLE;
        end else begin
            flags_q.valid <= gate.fall;
            if (gate.fall) begin
                ticks_q     <= (count == '0) ? MIN_TICKS : count;
                flags_q.ovf <= wrapped;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) ready_q <= 1'b0;
        else       ready_q <= 1'b1;
    end

    assign busy_o       = trig_s;
    assign ready_o      = ready_q;
    assign meas_valid_o = flags_q.valid;
    assign meas_ticks_o = ticks_q;
    assign meas_ovf_o   = flags_q.ovf;
endmodule

// File: rtl/ipt_gated_timer_chk.sv
module ipt_gated_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             busy_o,
    input logic             ready_o,
    input logic             meas_valid_o,
    input logic [CNT_W-1:0] meas_ticks_o,
    input logic             meas_ovf_o
);
    AST_VALID_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        meas_valid_o |=> !meas_valid_o);                                  // R4

    AST_VALID_AFTER_FALL: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(busy_o) |=> meas_valid_o);                                  // R4

    AST_TICKS_NONZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        meas_valid_o |-> (meas_ticks_o != '0));                           // R5

    AST_READY_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
        !rst_i |=> ready_o);                                              // R9

    AST_RESULT_STABLE: assert property (@(posedge clk_i) disable iff (rst_i)
        (!meas_valid_o && $past(!rst_i)) |-> ($stable(meas_ticks_o) && $stable(meas_ovf_o))); // R6
endmodule

bind ipt_gated_timer ipt_gated_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .busy_o       (busy_o),
    .ready_o      (ready_o),
    .meas_valid_o (meas_valid_o),
    .meas_ticks_o (meas_ticks_o),
    .meas_ovf_o   (meas_ovf_o)
);

// File: tb/tb_ipt_gated_timer.sv
`timescale 1ns/1ps
module tb_ipt_gated_timer;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         trig = 1'b0;
    logic         busy, ready, mvalid, movf;
    logic [W-1:0] mticks;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;   // 125 MHz

    ipt_gated_timer #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk_i(clk), .rst_i(rst), .trig_i(trig),
        .busy_o(busy), .ready_o(ready), .meas_valid_o(mvalid),
        .meas_ticks_o(mticks), .meas_ovf_o(movf)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // One active interval of n clock periods; trigger is driven on negedges
    task automatic run_pulse(input int n, input int exp_ticks, input int exp_ovf, input string req);
        @(negedge clk); trig = 1'b1;
        tick(1); check("R1", "busy one edge after rise", busy, 0);
        tick(1); check("R1", "busy two edges after rise", busy, 1);
        // busy has been high for 1 cycle; wait until n high cycles total
        tick(n - 2);
        trig = 1'b0;
        tick(1); check("R10", "busy still high before sync", busy, 1);
        tick(1); check("R10", "busy low", busy, 0);
        check("R4", "no early valid", mvalid, 0);
        tick(1);
        check("R4", "valid strobe", mvalid, 1);
        check(req, "ticks", mticks, exp_ticks);
        check(req, "ovf", movf, exp_ovf);
        tick(1);
        check("R4", "valid single cycle", mvalid, 0);
        check(req, "ticks held", mticks, exp_ticks);
    endtask

    task automatic t_reset();
        rst = 1'b1; trig = 1'b1;
        tick(4);
        check("R8", "valid in reset", mvalid, 0);
        check("R8", "busy in reset", busy, 0);
        check("R8", "ready in reset", ready, 0);
        check("R8", "ticks in reset", mticks, 0);
        check("R8", "ovf in reset", movf, 0);
        trig = 1'b0;
        tick(2);
        rst = 1'b0;
        tick(1);
        check("R9", "ready after reset", ready, 1);
        tick(5);
        check("R9", "ready held", ready, 1);
    endtask

    task automatic t_basic();
        run_pulse(10, 10, 0, "R2");
        run_pulse(3, 3, 0, "R2");
    endtask

    task automatic t_idle_gap();
        tick(40);   // long idle must not accumulate
        run_pulse(7, 7, 0, "R3");
    endtask

    task automatic t_minimum();
        // one clock period high: sampled exactly once
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
        tick(3);
        check("R5", "valid for shortest interval", mvalid, 1);
        check("R5", "shortest interval ticks", mticks, 1);
        tick(2);
    endtask

    task automatic t_overflow();
        run_pulse(255, 255, 0, "R6");
        run_pulse(256, 1, 1, "R5");     // exact wrap clamps to one tick
        run_pulse(261, 5, 1, "R6");
        run_pulse(4, 4, 0, "R7");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_idle_gap();
        t_minimum();
        t_overflow();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule